// File: doc/BRIEF.md
# Time-Slotted Shared Bus Arbiter

This block decides which of several cores may drive a single bus to main memory. The decision follows a fixed, repeating schedule. A small on-chip table lists the slots of one schedule period, and each entry names the core that owns that slot. Each slot lasts a set number of clock cycles. When the last slot ends, the arbiter goes back to the first one and repeats the schedule indefinitely. Because requests from other cores never change whose turn it is, the waiting time of any core can be bounded without knowing what the other cores are doing.

A controller fills the table while the arbiter is halted. It then raises the run enable. From that point the arbiter walks through the slots. In each cycle it grants the bus to the owner of the current slot, but only if that owner is requesting. If the owner is not requesting, the slot goes unused and no other core receives it. The current slot index is an output, so every core can see whose turn it is.

The controller is a two-state machine. In `ST_IDLE` the table can be written, the grant is held at zero and the slot index is held at zero. In `ST_RUN` the schedule advances. Transition START moves `ST_IDLE` to `ST_RUN` when `run_en` is sampled high. Transition HALT moves `ST_RUN` back to `ST_IDLE` when `run_en` is sampled low. Each state also has a self-loop: IDLE_HOLD keeps `ST_IDLE` while `run_en` stays low, and RUN_HOLD keeps `ST_RUN` while `run_en` stays high.

Top module: `tdma_bus_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `slot_idx` is 0, the machine is in `ST_IDLE`, and table entry i holds core i mod NUM_CORES.
- R2: In `ST_IDLE`, a cycle with `tbl_we` high and `tbl_idx` below SCHED_LEN stores `tbl_core` into entry `tbl_idx`.
- R3: A table write made while the machine is in `ST_RUN` has no effect on the table.
- R4: In the first cycle after `run_en` is sampled high in `ST_IDLE`, the machine is in `ST_RUN` with `slot_idx` 0, and that slot is at its first cycle.
- R5: While running, each slot lasts exactly SLOT_CYCLES cycles, and `slot_idx` then increases by one.
- R6: After the last slot (SCHED_LEN-1), `slot_idx` returns to 0, so the schedule repeats with a period of SCHED_LEN×SLOT_CYCLES cycles.
- R7: While running, `grant` has bit c set, and no other bit, exactly when core c owns the current slot and `req[c]` is high; `grant` never has more than one bit set.
- R8: A requesting core that does not own the current slot gets no grant. A slot whose owner is not requesting leaves `grant` at zero.
- R9: In the first cycle after `run_en` is sampled low while running, the machine is in `ST_IDLE`, `grant` is zero and `slot_idx` is 0.
- R10: A core that owns one slot and requests continuously from the start of the schedule receives its grant within SCHED_LEN×SLOT_CYCLES cycles; the first grant comes at cycle k×SLOT_CYCLES, where k is the index of its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High: run the schedule. Low: halt the schedule and allow table writes |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_core | input | CID_W | Core number to store in the entry |
| req | input | NUM_CORES | Bus request, one bit per core |
| grant | output | NUM_CORES | One-hot bus grant (all zero when no grant) |
| slot_idx | output | IDX_W | Index of the current slot |

## Verification
`grant` is combinational from the registered slot state and the live `req`. The bench therefore changes `req` at a falling edge and checks `grant` 1 ns later in the same cycle. `slot_idx` and the state change one clock edge after `run_en` is sampled. The bench starts counting schedule cycles at the first falling edge after that edge, and at count j it expects slot (j / SLOT_CYCLES) mod SCHED_LEN. A table write takes effect at the next edge. A write made while running is checked later, after a halt and a restart, by watching which core is granted in the affected slot. The worst-case wait is measured as the number of cycles from the start of the schedule to the first grant.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table #(
    parameter int SCHED_LEN = 6,
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 3,
    parameter int CID_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CID_W-1:0] wr_core,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CID_W-1:0] rd_core
);
    logic [SCHED_LEN-1:0][CID_W-1:0] mem_q;
    logic                            wr_ok;

    assign wr_ok = wr_en && !lock &&
                   ({{(32-IDX_W){1'b0}}, wr_idx} < 32'(SCHED_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SCHED_LEN; i++) begin
                mem_q[i] <= CID_W'(i % NUM_CORES);
            end
        end else if (wr_ok) begin
            mem_q[wr_idx] <= wr_core;
        end
    end

    assign rd_core = mem_q[rd_idx];

    // R3: table contents frozen while the schedule runs
    a_r3_locked_table: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en) |=> (mem_q == $past(mem_q)));
endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
    parameter int SCHED_LEN   = 6,
    parameter int SLOT_CYCLES = 3,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [IDX_W-1:0] idx,
    output logic             slot_end
);
    localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SCHED_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    assign slot_end = (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (slot_end) begin
            cnt_q <= '0;
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx = idx_q;

    // R5: index holds inside a slot
    a_r5_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !slot_end) |=> $stable(idx));
    // R5: index steps by one at slot end
    a_r5_step_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && slot_end && idx != IDX_LAST) |=> (idx == $past(idx) + 1'b1));
    // R6: schedule wraps to entry zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && slot_end && idx == IDX_LAST) |=> (idx == '0));
endmodule

// File: rtl/tdma_bus_arbiter.sv
module tdma_bus_arbiter
    import tdma_arb_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int SCHED_LEN   = 6,
    parameter int SLOT_CYCLES = 3,
    localparam int IDX_W = (SCHED_LEN > 1) ? $clog2(SCHED_LEN) : 1,
    localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_idx,
    input  logic [CID_W-1:0]     tbl_core,
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] grant,
    output logic [IDX_W-1:0]     slot_idx
);
    arb_state_e       state_q, state_d;
    logic             running;
    logic             timer_clr;
    logic             slot_end;
    logic [CID_W-1:0] owner;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_en)  state_d = ST_RUN;   // START
            ST_RUN:  if (!run_en) state_d = ST_IDLE;  // HALT
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign running   = (state_q == ST_RUN);
    assign timer_clr = !running || !run_en;

    tdma_sched_table #(
        .SCHED_LEN(SCHED_LEN), .NUM_CORES(NUM_CORES),
        .IDX_W(IDX_W), .CID_W(CID_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .lock(running),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_core(tbl_core),
        .rd_idx(slot_idx), .rd_core(owner)
    );

    tdma_slot_timer #(
        .SCHED_LEN(SCHED_LEN), .SLOT_CYCLES(SLOT_CYCLES), .IDX_W(IDX_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr),
        .idx(slot_idx), .slot_end(slot_end)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_grant
        assign grant[c] = running && (owner == CID_W'(c)) && req[c];
    end

    // R7: never more than one core on the bus
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8: a grant only ever goes to a requester
    a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req) == '0));
    // R9: halted arbiter is silent and parked at slot zero
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running) |-> (grant == '0 && slot_idx == '0));
    // R4: start puts the schedule at entry zero
    a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && run_en) |=> (running && slot_idx == '0));
endmodule

// File: tb/tdma_bus_arbiter_bench.sv
`timescale 1ns/1ps
module tdma_bus_arbiter_bench;
    localparam int N   = 4;
    localparam int LEN = 6;
    localparam int S   = 3;
    localparam int IW  = 3;
    localparam int CW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [CW-1:0] tbl_core = '0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  grant;
    logic [IW-1:0] slot_idx;

    int total = 0;
    int bad = 0;
    int model_tbl [LEN];

    always #2.5 clk = ~clk;

    tdma_bus_arbiter #(.NUM_CORES(N), .SCHED_LEN(LEN), .SLOT_CYCLES(S)) u_tdma_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_core(tbl_core), .req(req),
        .grant(grant), .slot_idx(slot_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_grant(input int owner, input logic [N-1:0] r);
        return r[owner] ? (1 << owner) : 0;
    endfunction

    task automatic write_entry(input int i, input int core);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(i); tbl_core = CW'(core);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic start_run;
        @(negedge clk);
        run_en = 1'b1;
        @(posedge clk);
    endtask

    task automatic stop_run;
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(grant == '0, "R9 grant after halt", int'(grant), 0);
        chk(slot_idx == '0, "R9 slot after halt", int'(slot_idx), 0);
    endtask

    // mode 0: all request; mode 1: sweep all request masks
    task automatic run_check(input int cycles, input int mode);
        for (int j = 0; j < cycles; j++) begin
            int s;
            int eg;
            @(negedge clk);
            req = (mode == 0) ? '1 : N'((j * 5 + 3) % 16);
            #1;
            s = (j / S) % LEN;
            if (j == 0)
                chk(slot_idx == IW'(s), "R4 first slot", int'(slot_idx), s);
            else if (j >= S && (j % (LEN * S)) < S)
                chk(slot_idx == IW'(s), "R6 wrap slot", int'(slot_idx), s);
            else
                chk(slot_idx == IW'(s), "R5 slot index", int'(slot_idx), s);
            eg = exp_grant(model_tbl[s], req);
            if (eg != 0)
                chk(int'(grant) == eg, "R7 owner grant", int'(grant), eg);
            else
                chk(grant == '0, "R8 no grant", int'(grant), 0);
        end
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wait_cyc;
        for (int i = 0; i < LEN; i++) model_tbl[i] = i % N;
        #12;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(grant == '0, "R1 grant at reset", int'(grant), 0);
        chk(slot_idx == '0, "R1 slot at reset", int'(slot_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(grant == '0, "R1 idle grant", int'(grant), 0);

        // R1 default table observed through grants over two periods
        start_run;
        run_check(2 * LEN * S, 0);
        stop_run;

        // R2 program a new table while idle
        begin
            int pat [LEN] = '{2, 2, 0, 3, 1, 0};
            for (int i = 0; i < LEN; i++) begin
                write_entry(i, pat[i]);
                model_tbl[i] = pat[i];
            end
        end
        start_run;
        run_check(2 * LEN * S, 0);
        // R3 write attempt while running, entry 3 to core 1
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(3); tbl_core = CW'(1);
        @(negedge clk);
        tbl_we = 1'b0;
        stop_run;
        // restart: entry 3 must still be core 3
        start_run;
        run_check(LEN * S, 0);
        stop_run;

        // R7 R8 sweep over request masks
        start_run;
        run_check(3 * LEN * S, 1);
        stop_run;

        // R10 worst-case wait: core 3 owns only the last slot
        for (int i = 0; i < LEN; i++) begin
            write_entry(i, (i == LEN - 1) ? 3 : 0);
            model_tbl[i] = (i == LEN - 1) ? 3 : 0;
        end
        @(negedge clk);
        req = 4'b1000;
        start_run;
        wait_cyc = -1;
        for (int j = 0; j < 2 * LEN * S && wait_cyc < 0; j++) begin
            @(negedge clk);
            #1;
            if (grant[3]) wait_cyc = j;
        end
        chk(wait_cyc == (LEN - 1) * S, "R10 first grant cycle", wait_cyc, (LEN - 1) * S);
        chk(wait_cyc >= 0 && wait_cyc <= LEN * S, "R10 bound", wait_cyc, LEN * S);
        stop_run;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule